// File: doc/BRIEF.md
# Trap Entry and Fault Capture Unit

This unit sits at the back of a processor pipeline and turns fault requests into an entry into the privileged handler. Each cycle it looks at a vector of request lines, one line per fault cause, and when any line is active it picks a single cause in a fixed order. It records where execution should resume, latches diagnostic state for translation faults, and produces the handler address that the fetch stage must jump to.

The handler address is a programmable base plus a fixed 16-bit offset chosen by the cause. The unit keeps three programmable values: the handler base and two page-table bases, one for data and one for instruction translation. A single write port loads them. When a data or instruction translation fault is entered, the unit builds a status word from the faulting instruction and forms the address of the page-table entry that maps the faulting page. Capture is withheld for accesses that should leave no trace: misspeculated ones, page-table-entry fetches and no-fault probes. The redirect still happens in those cases.

Top module: `trap_entry`

## Requirements
- R1: While `rst` is high at a clock edge, every output register and the three programmable bases are cleared to zero.
- R2: One cycle after a clock edge at which any `flt_req` bit is set, `redirect_valid` is 1, `new_pc` equals the handler base plus the zero-extended offset of the chosen cause, and `next_pc` equals `new_pc` plus 4. The handler base used is the value held before that edge.
- R3: Cause index to offset: 0 reset 0x0001, 1 machine check 0x0401, 2 single data miss 0x0201, 3 double data miss 0x0281, 4 data alignment 0x0301, 5 data fault or access violation 0x0381, 6 instruction page fault 0x0181, 7 instruction access violation 0x0081, 8 interrupt 0x0101, 9 illegal opcode 0x0481, 10 arithmetic or overflow 0x0501, 11 float disabled 0x0581, 12 privileged call 0x2001.
- R4: When several bits are set, the lowest index wins, so reset beats machine check, which beats the translation faults, which beat everything else. `trap_id` shows the index that was entered.
- R5: The exception address is loaded with `cur_pc` for every cause except interrupt. For an interrupt it is loaded only when `cur_pc[1:0]` is 00, and otherwise it keeps its previous value.
- R6: For arithmetic (10) and privileged call (12) the stored exception address is the value from R5 plus 4.
- R7: On an entered data translation fault (indices 2 to 5) that is not suppressed, `dfault_va` captures `data_va` and `dfault_stat` becomes {inst_word[31:26], inst_word[25:21], acc_flags[5:0]}. These occupy bits 16:11, 10:6 and 5:0, and the upper bits are zero.
- R8: On the same condition, `dfault_form` becomes the data page-table base ORed with `data_va[63:13]` shifted left by 3.
- R9: Data capture is suppressed when `misspec`, `pte_fetch` or `no_fault` is high. The three data capture outputs then keep their values while the redirect of R2 still occurs.
- R10: On an entered instruction translation fault (6 or 7) with `misspec` low, `ifault_tag` captures `cur_pc` and `ifault_form` becomes the instruction page-table base ORed with `cur_pc[63:13]` shifted left by 3. With `misspec` high, both keep their values.
- R11: A write with `cfg_we` high loads `cfg_wdata` into the base selected by `cfg_sel`: 0 handler base, 1 data page-table base, 2 instruction page-table base. Select 3 is ignored.
- R12: After an edge with no request bit set, `redirect_valid` is 0 and every other output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Base register write enable |
| cfg_sel | input | 2 | Base register select |
| cfg_wdata | input | 64 | Base register write value |
| flt_req | input | 13 | Fault request lines, one per cause |
| cur_pc | input | 64 | PC of the faulting instruction |
| inst_word | input | 32 | Faulting instruction word |
| data_va | input | 64 | Data virtual address of the access |
| acc_flags | input | 6 | Access flags packed into the status word |
| misspec | input | 1 | Access is misspeculated |
| pte_fetch | input | 1 | Access is a page-table-entry fetch |
| no_fault | input | 1 | Access is a no-fault probe |
| redirect_valid | output | 1 | Handler redirect this cycle |
| trap_id | output | 4 | Index of the entered cause |
| new_pc | output | 64 | Handler entry PC |
| next_pc | output | 64 | Handler entry PC plus 4 |
| exc_addr | output | 64 | Exception restart address |
| dfault_va | output | 64 | Captured data fault address |
| dfault_stat | output | 64 | Packed data fault status |
| dfault_form | output | 64 | Data page-table-entry address |
| ifault_tag | output | 64 | Captured instruction fault PC |
| ifault_form | output | 64 | Instruction page-table-entry address |

## Verification
The bench builds the unit with its default parameters: 64-bit addresses, a 13-bit page offset and 16-bit offsets. These reach the top bits of the page number in both formatted addresses, the 0x2001 offset that needs the full offset width, and carries out of the low half when the base and offset are added. Random PCs with all four low-bit patterns exercise both branches of the interrupt load rule.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NF   = 13;
  localparam int ID_W = $clog2(NF);

  typedef enum logic [1:0] {
    CFG_HBASE = 2'd0,
    CFG_DPTB  = 2'd1,
    CFG_IPTB  = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  // cause indices double as priority: lower wins
  localparam logic [ID_W-1:0] ID_RESET  = 4'd0;
  localparam logic [ID_W-1:0] ID_MCHK   = 4'd1;
  localparam logic [ID_W-1:0] ID_DMISS1 = 4'd2;
  localparam logic [ID_W-1:0] ID_DMISS2 = 4'd3;
  localparam logic [ID_W-1:0] ID_DALIGN = 4'd4;
  localparam logic [ID_W-1:0] ID_DFAULT = 4'd5;
  localparam logic [ID_W-1:0] ID_IPAGE  = 4'd6;
  localparam logic [ID_W-1:0] ID_IACV   = 4'd7;
  localparam logic [ID_W-1:0] ID_INTR   = 4'd8;
  localparam logic [ID_W-1:0] ID_OPDEC  = 4'd9;
  localparam logic [ID_W-1:0] ID_ARITH  = 4'd10;
  localparam logic [ID_W-1:0] ID_FEN    = 4'd11;
  localparam logic [ID_W-1:0] ID_PAL    = 4'd12;
endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
  parameter int N    = 13,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    req,
  output logic            any,
  output logic [ID_W-1:0] win
);
  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) win = ID_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/trap_decode.sv
module trap_decode
  import trap_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic [ID_W-1:0]  id,
  output logic [VEC_W-1:0] vec,
  output logic             force_load,
  output logic             skip_inst,
  output logic             is_data,
  output logic             is_instr
);
  always_comb begin
    unique case (id)
      ID_RESET:  vec = VEC_W'(16'h0001);
      ID_MCHK:   vec = VEC_W'(16'h0401);
      ID_DMISS1: vec = VEC_W'(16'h0201);
      ID_DMISS2: vec = VEC_W'(16'h0281);
      ID_DALIGN: vec = VEC_W'(16'h0301);
      ID_DFAULT: vec = VEC_W'(16'h0381);
      ID_IPAGE:  vec = VEC_W'(16'h0181);
      ID_IACV:   vec = VEC_W'(16'h0081);
      ID_INTR:   vec = VEC_W'(16'h0101);
      ID_OPDEC:  vec = VEC_W'(16'h0481);
      ID_ARITH:  vec = VEC_W'(16'h0501);
      ID_FEN:    vec = VEC_W'(16'h0581);
      ID_PAL:    vec = VEC_W'(16'h2001);
      default:   vec = '0;
    endcase
  end

  assign force_load = (id != ID_INTR);
  assign skip_inst  = (id == ID_ARITH) || (id == ID_PAL);
  assign is_data    = (id >= ID_DMISS1) && (id <= ID_DFAULT);
  assign is_instr   = (id == ID_IPAGE) || (id == ID_IACV);
endmodule

// File: rtl/trap_capture.sv
module trap_capture #(
  parameter int XLEN    = 64,
  parameter int PG_BITS = 13,
  parameter int INST_W  = 32,
  parameter int FLAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_d,
  input  logic              take_i,
  input  logic [INST_W-1:0] inst_word,
  input  logic [XLEN-1:0]   data_va,
  input  logic [FLAG_W-1:0] acc_flags,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   dptb,
  input  logic [XLEN-1:0]   iptb,
  output logic [XLEN-1:0]   dfault_va,
  output logic [XLEN-1:0]   dfault_stat,
  output logic [XLEN-1:0]   dfault_form,
  output logic [XLEN-1:0]   ifault_tag,
  output logic [XLEN-1:0]   ifault_form
);
  localparam int OP_W  = 6;
  localparam int RA_W  = 5;
  localparam int ST_W  = OP_W + RA_W + FLAG_W;
  localparam int VPN_W = XLEN - PG_BITS;

  logic [ST_W-1:0]  stat_word;
  logic [XLEN-1:0]  d_pte, i_pte;
  logic [VPN_W-1:0] d_vpn, i_vpn;

  assign d_vpn     = data_va[XLEN-1:PG_BITS];
  assign i_vpn     = cur_pc[XLEN-1:PG_BITS];
  assign stat_word = {inst_word[INST_W-1 -: OP_W],
                      inst_word[INST_W-OP_W-1 -: RA_W],
                      acc_flags};
  assign d_pte     = dptb | XLEN'({d_vpn, 3'b000});
  assign i_pte     = iptb | XLEN'({i_vpn, 3'b000});

  always_ff @(posedge clk) begin
    if (rst) begin
      dfault_va   <= '0;
      dfault_stat <= '0;
      dfault_form <= '0;
    end else if (take_d) begin
      dfault_va   <= data_va;
      dfault_stat <= XLEN'(stat_word);
      dfault_form <= d_pte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ifault_tag  <= '0;
      ifault_form <= '0;
    end else if (take_i) begin
      ifault_tag  <= cur_pc;
      ifault_form <= i_pte;
    end
  end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int PG_BITS = 13,
  parameter int VEC_W   = 16,
  parameter int INST_W  = 32,
  parameter int FLAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [XLEN-1:0]   cfg_wdata,
  input  logic [NF-1:0]     flt_req,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [INST_W-1:0] inst_word,
  input  logic [XLEN-1:0]   data_va,
  input  logic [FLAG_W-1:0] acc_flags,
  input  logic              misspec,
  input  logic              pte_fetch,
  input  logic              no_fault,
  output logic              redirect_valid,
  output logic [ID_W-1:0]   trap_id,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   next_pc,
  output logic [XLEN-1:0]   exc_addr,
  output logic [XLEN-1:0]   dfault_va,
  output logic [XLEN-1:0]   dfault_stat,
  output logic [XLEN-1:0]   dfault_form,
  output logic [XLEN-1:0]   ifault_tag,
  output logic [XLEN-1:0]   ifault_form
);
  localparam logic [XLEN-1:0] INST_BYTES = XLEN'(4);

  logic             any_req;
  logic [ID_W-1:0]  win_id;
  logic [VEC_W-1:0] vec;
  logic             force_load, skip_inst, is_data, is_instr;
  logic [XLEN-1:0]  hbase_q, dptb_q, iptb_q;
  logic [XLEN-1:0]  entry_pc, ea_loaded, ea_next;
  logic             take_d, take_i;

  trap_prio #(.N(NF), .ID_W(ID_W)) u_prio (
    .req (flt_req),
    .any (any_req),
    .win (win_id)
  );

  trap_decode #(.VEC_W(VEC_W)) u_dec (
    .id         (win_id),
    .vec        (vec),
    .force_load (force_load),
    .skip_inst  (skip_inst),
    .is_data    (is_data),
    .is_instr   (is_instr)
  );

  assign entry_pc  = hbase_q + XLEN'(vec);
  assign ea_loaded = (force_load || (cur_pc[1:0] == 2'b00)) ? cur_pc : exc_addr;
  assign ea_next   = skip_inst ? ea_loaded + INST_BYTES : ea_loaded;
  assign take_d    = any_req && is_data && !misspec && !pte_fetch && !no_fault;
  assign take_i    = any_req && is_instr && !misspec;

  always_ff @(posedge clk) begin
    if (rst) begin
      hbase_q <= '0;
      dptb_q  <= '0;
      iptb_q  <= '0;
    end else if (cfg_we) begin
      unique case (cfg_sel_e'(cfg_sel))
        CFG_HBASE: hbase_q <= cfg_wdata;
        CFG_DPTB:  dptb_q  <= cfg_wdata;
        CFG_IPTB:  iptb_q  <= cfg_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      trap_id        <= '0;
      new_pc         <= '0;
      next_pc        <= '0;
      exc_addr       <= '0;
    end else begin
      redirect_valid <= any_req;
      if (any_req) begin
        trap_id  <= win_id;
        new_pc   <= entry_pc;
        next_pc  <= entry_pc + INST_BYTES;
        exc_addr <= ea_next;
      end
    end
  end

  trap_capture #(
    .XLEN(XLEN), .PG_BITS(PG_BITS), .INST_W(INST_W), .FLAG_W(FLAG_W)
  ) u_cap (
    .clk         (clk),
    .rst         (rst),
    .take_d      (take_d),
    .take_i      (take_i),
    .inst_word   (inst_word),
    .data_va     (data_va),
    .acc_flags   (acc_flags),
    .cur_pc      (cur_pc),
    .dptb        (dptb_q),
    .iptb        (iptb_q),
    .dfault_va   (dfault_va),
    .dfault_stat (dfault_stat),
    .dfault_form (dfault_form),
    .ifault_tag  (ifault_tag),
    .ifault_form (ifault_form)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [NF-1:0]   flt_req,
  input logic            misspec,
  input logic            pte_fetch,
  input logic            no_fault,
  input logic            redirect_valid,
  input logic [ID_W-1:0] trap_id,
  input logic [XLEN-1:0] new_pc,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] exc_addr,
  input logic [XLEN-1:0] dfault_va,
  input logic [XLEN-1:0] dfault_stat,
  input logic [XLEN-1:0] ifault_tag
);
  // R2: a request is answered by a redirect on the next cycle
  p_redirect_r2: assert property (@(posedge clk) disable iff (rst)
    (|flt_req) |=> redirect_valid);

  // R2: handler next PC is one instruction past the entry PC
  p_nextpc_r2: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (next_pc == new_pc + XLEN'(4)));

  // R4: the entered cause is one of the requested lines
  p_req_r4: assert property (@(posedge clk) disable iff (rst)
    (|flt_req) |=> ($past(flt_req) >> trap_id) & NF'(1));

  // R9: suppressed data accesses leave the capture state alone
  p_dsupp_r9: assert property (@(posedge clk) disable iff (rst)
    ((|flt_req) && (misspec || pte_fetch || no_fault)) |=>
      ($stable(dfault_va) && $stable(dfault_stat)));

  // R10: misspeculated instruction faults leave the tag alone
  p_isupp_r10: assert property (@(posedge clk) disable iff (rst)
    ((|flt_req) && misspec) |=> $stable(ifault_tag));

  // R12: idle cycles hold the redirect state
  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !(|flt_req) |=> (!redirect_valid && $stable(new_pc) && $stable(exc_addr)));
endmodule

bind trap_entry trap_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_trap_entry.sv
module tb_trap_entry;
  localparam int NF = 13;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [63:0] cfg_wdata;
  logic [NF-1:0] flt_req;
  logic [63:0] cur_pc;
  logic [31:0] inst_word;
  logic [63:0] data_va;
  logic [5:0]  acc_flags;
  logic        misspec, pte_fetch, no_fault;
  logic        redirect_valid;
  logic [3:0]  trap_id;
  logic [63:0] new_pc, next_pc, exc_addr, dfault_va, dfault_stat, dfault_form;
  logic [63:0] ifault_tag, ifault_form;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic        e_rv;
  logic [3:0]  e_id;
  logic [63:0] e_np, e_nnp, e_ea, e_dva, e_dst, e_dfm, e_itg, e_ifm;
  logic [63:0] m_base, m_dptb, m_iptb;

  always #5 clk = ~clk;

  trap_entry dut (.*);

  function automatic logic [63:0] bvec(int i);
    case (i)
      0: return 64'h0001;   1: return 64'h0401;   2: return 64'h0201;
      3: return 64'h0281;   4: return 64'h0301;   5: return 64'h0381;
      6: return 64'h0181;   7: return 64'h0081;   8: return 64'h0101;
      9: return 64'h0481;  10: return 64'h0501;  11: return 64'h0581;
      default: return 64'h2001;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic predict();
    int w;
    if (rst) begin
      {e_rv, e_id} = '0;
      {e_np, e_nnp, e_ea, e_dva, e_dst, e_dfm, e_itg, e_ifm} = '0;
      {m_base, m_dptb, m_iptb} = '0;
      return;
    end
    e_rv = |flt_req;
    if (e_rv) begin
      w = -1;
      for (int i = 0; i < NF; i++) if (w < 0 && flt_req[i]) w = i;
      e_id  = 4'(w);
      e_np  = m_base + bvec(w);
      e_nnp = e_np + 4;
      if (w != 8 || cur_pc[1:0] == 2'b00) e_ea = cur_pc;
      if (w == 10 || w == 12) e_ea = e_ea + 4;
      if (w >= 2 && w <= 5 && !misspec && !pte_fetch && !no_fault) begin
        e_dva = data_va;
        e_dst = (64'(inst_word[31:26]) << 11) | (64'(inst_word[25:21]) << 6)
                | 64'(acc_flags);
        e_dfm = m_dptb | ((data_va >> 13) << 3);
      end
      if ((w == 6 || w == 7) && !misspec) begin
        e_itg = cur_pc;
        e_ifm = m_iptb | ((cur_pc >> 13) << 3);
      end
    end
    if (cfg_we) begin
      if (cfg_sel == 2'd0) m_base = cfg_wdata;
      else if (cfg_sel == 2'd1) m_dptb = cfg_wdata;
      else if (cfg_sel == 2'd2) m_iptb = cfg_wdata;
    end
  endtask

  task automatic compare_all();
    check("R2 redirect_valid", 64'(redirect_valid), 64'(e_rv));
    check("R4 trap_id", 64'(trap_id), 64'(e_id));
    check("R2 new_pc", new_pc, e_np);
    check("R2 next_pc", next_pc, e_nnp);
    check("R5 exc_addr", exc_addr, e_ea);
    check("R7 dfault_va", dfault_va, e_dva);
    check("R7 dfault_stat", dfault_stat, e_dst);
    check("R8 dfault_form", dfault_form, e_dfm);
    check("R10 ifault_tag", ifault_tag, e_itg);
    check("R10 ifault_form", ifault_form, e_ifm);
  endtask

  task automatic run_cycle();
    predict();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; flt_req = '0;
    misspec = 0; pte_fetch = 0; no_fault = 0;
  endtask

  task automatic cfg(logic [1:0] s, logic [63:0] v);
    idle(); cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    run_cycle();
    idle();
  endtask

  initial begin
    logic [63:0] keep_va, keep_tag;
    idle();
    rst = 1; cur_pc = 0; inst_word = 0; data_va = 0; acc_flags = 0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) run_cycle();
    rst = 0;
    run_cycle();
    // R1: outputs cleared by reset
    check("R1 new_pc", new_pc, 64'h0);
    check("R1 exc_addr", exc_addr, 64'h0);
    check("R1 dfault_form", dfault_form, 64'h0);

    // R11: program the bases, including an ignored select 3
    cfg(2'd0, 64'h0000_0000_1234_F000);
    cfg(2'd1, 64'hFFF0_0000_0000_0000);
    cfg(2'd2, 64'h0AB0_0000_0000_0000);
    cfg(2'd3, 64'hDEAD_BEEF_DEAD_BEEF);

    // R3: every cause lands at base plus its offset
    for (int i = 0; i < NF; i++) begin
      idle(); flt_req = NF'(1) << i;
      cur_pc = 64'h0000_7FFF_FFFF_E000 + 64'(i * 4);
      data_va = 64'hFFFF_FFFF_FFFF_E123; inst_word = 32'hA7E1_0000 + i;
      acc_flags = 6'(i);
      run_cycle();
      check("R3 vector", new_pc, 64'h0000_0000_1234_F000 + bvec(i));
      check("R11 base used", new_pc - bvec(i), 64'h0000_0000_1234_F000);
    end

    // R6: privileged call skips the faulting instruction
    idle(); flt_req = NF'(1) << 12; cur_pc = 64'h1000;
    run_cycle();
    check("R6 skip", exc_addr, 64'h1004);

    // R5: interrupt with unaligned PC keeps the old address
    idle(); flt_req = NF'(1) << 8; cur_pc = 64'h2001;
    run_cycle();
    check("R5 interrupt keep", exc_addr, 64'h1004);

    // R4: reset cause beats all others
    idle(); flt_req = '1;
    run_cycle();
    check("R4 priority", 64'(trap_id), 64'h0);

    // R9: suppressed data capture, redirect still taken
    keep_va = dfault_va;
    for (int k = 0; k < 3; k++) begin
      idle(); flt_req = NF'(1) << 3; data_va = 64'h5555_0000 + 64'(k);
      misspec = (k == 0); pte_fetch = (k == 1); no_fault = (k == 2);
      run_cycle();
      check("R9 va held", dfault_va, keep_va);
      check("R9 redirect", 64'(redirect_valid), 64'h1);
    end

    // R10: misspeculated instruction fault keeps the tag
    keep_tag = ifault_tag;
    idle(); flt_req = NF'(1) << 7; misspec = 1; cur_pc = 64'h9990;
    run_cycle();
    check("R10 tag held", ifault_tag, keep_tag);

    // R12: idle cycle
    idle();
    run_cycle();
    check("R12 idle", 64'(redirect_valid), 64'h0);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      idle();
      r = int'($urandom % 4);
      if (r == 1) flt_req = NF'(1) << ($urandom % NF);
      else if (r == 2) flt_req = NF'($urandom);
      cur_pc    = {$urandom, $urandom};
      data_va   = {$urandom, $urandom};
      inst_word = $urandom;
      acc_flags = 6'($urandom);
      misspec   = ($urandom % 5) == 0;
      pte_fetch = ($urandom % 6) == 0;
      no_fault  = ($urandom % 7) == 0;
      if (($urandom % 16) == 0) begin
        cfg_we = 1; cfg_sel = 2'($urandom); cfg_wdata = {$urandom, $urandom};
      end
      rst = ($urandom % 500) == 0;
      run_cycle();
      rst = 0;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule